// File: doc/BRIEF.md
# Out-of-Order Completion Reorder Buffer

This block puts back into issue order the results of operations that finish out of order. Before a requester starts an operation, it takes a token from the buffer. The token is the index of one of 16 storage slots. When the operation finishes, the result is written into the buffer under that token. The result side then gives the results out strictly in the order the tokens were issued. A result whose older neighbours are still pending waits in its slot.

The token and result sides are valid/ready streams. A token moves when `tok_valid` and `tok_ready` are both high. A result moves when `res_valid` and `res_ready` are both high. While `res_ready` is low, the offered result stays unchanged. The write-back side is always ready: a write is taken on every cycle that `put_valid` is high. Token issue, write-back and retirement can all happen in the same cycle, so a steady pipeline loses no cycles. Tokens that were never issued, or that are written twice, are not checked.

Top module: `cmpl_reorder`

## Requirements
- R1: After reset, `tok_valid` is 1, `tok_id` is 0 and `res_valid` is 0.
- R2: Tokens are issued as consecutive slot indices from 0 to 15, and the index after 15 is 0.
- R3: `tok_valid` is 0 while 16 tokens are outstanding. While it is 0, holding `tok_ready` high issues no token and leaves `tok_id` unchanged.
- R4: When a result retires, `res_data` equals the data that was written under the oldest outstanding token.
- R5: Results retire in token-issue order, whatever order the write-backs arrive in. `res_valid` is 1 only when the oldest outstanding token's slot has been written.
- R6: `res_valid` is 0 when no token is outstanding.
- R7: In the cycle in which the oldest slot is written, `res_valid` is still 0. It becomes 1 after that clock edge.
- R8: A token issue, a write-back and a retirement can complete in the same cycle. In a steady pipeline, all three happen on every cycle.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_data` does not change.
- R10: `put_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | output | 1 | A free slot is available as a token |
| tok_ready | input | 1 | Requester takes the offered token |
| tok_id | output | 4 | Offered token (slot index) |
| put_valid | input | 1 | Write-back of a result |
| put_ready | output | 1 | Write-back accepted (always 1) |
| put_tok | input | 4 | Token that the result belongs to |
| put_data | input | 32 | Result data |
| res_valid | output | 1 | Oldest result is ready to leave |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Oldest result data |

## Verification
The bench fills all 16 slots, then writes them back in reverse order. A design that forwarded results by completion order, or that looked at a slot other than the head, would release data too early or in the wrong order. It pushes issue past capacity and wraps both pointers; an off-by-one on the full limit or on the wrap would duplicate or skip a token. A pipeline that issues, writes back and retires on every cycle exposes counters that drop an increment or a decrement when both arrive together. It also exposes stores that lose one of two same-cycle writes. A long run with random back-pressure and random completion order is compared against an arithmetic model of slot contents and pointers.

// File: rtl/cmpl_pkg.sv
`timescale 1ns/1ps
package cmpl_pkg;
  parameter int CB_SLOTS  = 16;
  parameter int CB_DATA_W = 32;
endpackage

// File: rtl/cmpl_ring_ptr.sv
`timescale 1ns/1ps
module cmpl_ring_ptr #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] ptr
);
  localparam logic [W-1:0] LAST = W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr == LAST) |=> ptr == '0); // R2
endmodule

// File: rtl/cmpl_occ_cnt.sv
`timescale 1ns/1ps
module cmpl_occ_cnt #(
  parameter int MAX = 16,
  parameter int W   = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         full,
  output logic         empty
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + W'(inc) - W'(dec);
  end

  assign full  = (cnt == W'(MAX));
  assign empty = (cnt == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && inc) |-> dec); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !dec); // R6
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> cnt == $past(cnt)); // R8
endmodule

// File: rtl/cmpl_slot_store.sv
`timescale 1ns/1ps
module cmpl_slot_store #(
  parameter int SLOTS  = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic [DATA_W-1:0] set_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data
);
  logic [SLOTS-1:0]  filled_q;
  logic [SLOTS-1:0]  clr_mask, set_mask;
  logic [DATA_W-1:0] mem [SLOTS];

  // one decode per write port, built per slot
  for (genvar g = 0; g < SLOTS; g++) begin : g_dec
    assign clr_mask[g] = clr_en && (clr_idx == IDX_W'(g));
    assign set_mask[g] = set_en && (set_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) filled_q <= '0;
    else        filled_q <= (filled_q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (set_en) mem[set_idx] <= set_data;
  end

  assign rd_vld  = filled_q[rd_idx];
  assign rd_data = mem[rd_idx];

  AST_WRITE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_en) |-> clr_idx != set_idx); // R8
  AST_FILL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> filled_q[$past(set_idx)]); // R4
endmodule

// File: rtl/cmpl_reorder.sv
`timescale 1ns/1ps
module cmpl_reorder #(
  parameter int SLOTS  = cmpl_pkg::CB_SLOTS,
  parameter int DATA_W = cmpl_pkg::CB_DATA_W,
  localparam int TOK_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              tok_valid,
  input  logic              tok_ready,
  output logic [TOK_W-1:0]  tok_id,
  input  logic              put_valid,
  output logic              put_ready,
  input  logic [TOK_W-1:0]  put_tok,
  input  logic [DATA_W-1:0] put_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data
);
  logic             tok_fire, res_fire;
  logic [TOK_W-1:0] head;
  logic [CNT_W-1:0] occ;
  logic             occ_full, occ_empty, head_vld;

  assign tok_fire  = tok_valid && tok_ready;
  assign res_fire  = res_valid && res_ready;
  assign put_ready = 1'b1;

  cmpl_ring_ptr #(.DEPTH(SLOTS), .W(TOK_W)) u_in_ptr (
    .clk(clk), .rst_n(rst_n), .adv(tok_fire), .ptr(tok_id));

  cmpl_ring_ptr #(.DEPTH(SLOTS), .W(TOK_W)) u_out_ptr (
    .clk(clk), .rst_n(rst_n), .adv(res_fire), .ptr(head));

  cmpl_occ_cnt #(.MAX(SLOTS), .W(CNT_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .inc(tok_fire), .dec(res_fire),
    .cnt(occ), .full(occ_full), .empty(occ_empty));

  cmpl_slot_store #(.SLOTS(SLOTS), .IDX_W(TOK_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .clr_en(tok_fire), .clr_idx(tok_id),
    .set_en(put_valid), .set_idx(put_tok), .set_data(put_data),
    .rd_idx(head), .rd_vld(head_vld), .rd_data(res_data));

  assign tok_valid = !occ_full;
  assign res_valid = !occ_empty && head_vld;

  AST_TOK_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    tok_fire |=> tok_id == (($past(tok_id) == TOK_W'(SLOTS - 1)) ?
                            '0 : $past(tok_id) + 1'b1)); // R2
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!tok_valid && !res_fire) |=> !tok_valid && $stable(tok_id)); // R3
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_data)); // R9
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !res_valid); // R6
endmodule

// File: tb/test_cmpl_reorder.sv
`timescale 1ns/1ps
module test_cmpl_reorder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tok_valid, tok_ready = 1'b0;
  logic [3:0]  tok_id;
  logic        put_valid = 1'b0, put_ready;
  logic [3:0]  put_tok = '0;
  logic [31:0] put_data = '0;
  logic        res_valid, res_ready = 1'b0;
  logic [31:0] res_data;

  cmpl_reorder i_cmpl_reorder (
    .clk(clk), .rst_n(rst_n),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_id(tok_id),
    .put_valid(put_valid), .put_ready(put_ready), .put_tok(put_tok),
    .put_data(put_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_triple = 0, cyc = 0;
  logic [3:0]  m_hi = '0, m_ho = '0, m_last = '0;
  int          m_cnt = 0;
  logic        m_fill [16];
  logic        m_out  [16];
  logic [31:0] m_data [16];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit tr, input bit rr, input bit pv, input logic [3:0] pt);
    bit etv, erv, ptf, prf, pvf;
    logic [31:0] pd;
    @(negedge clk);
    etv = (m_cnt < 16);
    erv = (m_cnt > 0) && m_fill[m_ho];
    chk(put_ready === 1'b1, "R10", 32'(put_ready), 1);
    chk(tok_valid === etv, "R3", 32'(tok_valid), 32'(etv));
    if (etv) chk(tok_id === m_hi, "R2", 32'(tok_id), 32'(m_hi));
    chk(res_valid === erv, (m_cnt == 0) ? "R6" : "R5", 32'(res_valid), 32'(erv));
    if (erv) chk(res_data === m_data[m_ho], rr ? "R4" : "R9", res_data, m_data[m_ho]);
    pd = 32'h5A000000 ^ 32'(cyc * 16 + int'(pt));
    tok_ready = tr; res_ready = rr; put_valid = pv; put_tok = pt; put_data = pd;
    if (pv && m_cnt > 0 && pt == m_ho && !m_fill[m_ho]) begin
      #0.5;
      chk(res_valid === 1'b0, "R7", 32'(res_valid), 0);
    end
    ptf = etv && tr; prf = erv && rr; pvf = pv;
    if (pvf) begin m_fill[pt] = 1'b1; m_data[pt] = pd; end
    if (prf) begin m_out[m_ho] = 1'b0; m_ho = m_ho + 1'b1; m_cnt--; end
    if (ptf) begin
      m_fill[m_hi] = 1'b0; m_out[m_hi] = 1'b1; m_last = m_hi;
      m_hi = m_hi + 1'b1; m_cnt++;
    end
    if (ptf && prf && pvf) n_triple++;
    cyc++;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit issued, found;
    logic [3:0] pick;
    for (int s = 0; s < 16; s++) begin m_fill[s] = 0; m_out[s] = 0; m_data[s] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(tok_valid === 1'b1, "R1", 32'(tok_valid), 1);
    chk(tok_id === 4'd0, "R1", 32'(tok_id), 0);
    chk(res_valid === 1'b0, "R1", 32'(res_valid), 0);

    // fill all slots, then try to go past capacity (R2, R3)
    for (int k = 0; k < 16; k++) step(1, 0, 0, '0);
    for (int k = 0; k < 3; k++) step(1, 0, 0, '0);
    @(negedge clk);
    chk(tok_valid === 1'b0, "R3", 32'(tok_valid), 0);
    chk(tok_id === 4'd0, "R3", 32'(tok_id), 0);

    // write back newest first: nothing may leave before slot 0 (R5, R7)
    for (int k = 15; k >= 0; k--) step(0, 0, 1, 4'(k));
    for (int k = 0; k < 3; k++) step(0, 0, 0, '0); // back-pressure R9
    for (int k = 0; k < 18; k++) step(0, 1, 0, '0); // drain R4, R6

    // streaming: issue, write back previous token, retire each cycle (R8)
    issued = 0;
    n_triple = 0;
    for (int k = 0; k < 40; k++) begin
      step(1, 1, issued, m_last);
      issued = 1;
    end
    chk(n_triple >= 37, "R8", 32'(n_triple), 37);
    for (int k = 0; k < 4; k++) step(0, 1, m_out[m_ho] && !m_fill[m_ho], m_ho);
    for (int k = 0; k < 4; k++) step(0, 1, 0, '0);

    // random completion order and back-pressure (R2, R4, R5, R9)
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      found = 0; pick = '0;
      for (int j = 0; j < 16; j++) begin
        if (!found && m_out[4'(int'(lfsr[7:4]) + j)] && !m_fill[4'(int'(lfsr[7:4]) + j)]) begin
          found = 1; pick = 4'(int'(lfsr[7:4]) + j);
        end
      end
      step(lfsr[0] | lfsr[1], lfsr[2] | lfsr[9], found && (lfsr[3] | lfsr[8]), pick);
    end
    for (int k = 0; k < 100 && m_cnt > 0; k++) begin
      found = 0; pick = '0;
      for (int j = 0; j < 16; j++)
        if (!found && m_out[j] && !m_fill[j]) begin found = 1; pick = 4'(j); end
      step(0, 1, found, pick);
    end
    chk(m_cnt == 0, "R5", 32'(m_cnt), 0);
    step(0, 0, 0, '0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule